// File: doc/BRIEF.md
# Entropy Seed Register Unit

This unit is the processor-side control/status register through which software collects raw entropy, 16 bits per access. A CSR access presented on the access port is claimed only when its register number matches the configured seed address. The unit then judges the access from the instruction form, the current privilege level, the virtualization state and two enable bits kept in a local copy of the machine security configuration word. The outcome is one of three: a data word, an illegal-instruction exception or a virtual-instruction exception.

A granted access reads the entropy source through a valid/ready handshake and takes at most one sample, in the same cycle that the access retires. The returned word carries a 2-bit operational status in its top bits and the sample in its low half. A failure flag and a self-test flag from the source override the normal status. The verdict and the word are registered and appear one cycle after the access.

Top module: `entropy_seed_csr`

## Requirements
- R1: Only an access with `acc_valid`=1 and `acc_csr_num`=0x015 is claimed. It produces `rsp_valid`=1 in the following cycle. Any other CSR number gives no response and takes no sample.
- R2: A granted access that finds a sample ready, with no failure and no self-test, returns bits 31:30 = 2'b10 (ES16) and bits 15:0 = the sample. Bits 29:16 are always zero.
- R3: A granted access with `es_valid`=0 (and no failure or self-test) returns status 2'b01 (WAIT) with data bits zero, and holds `es_ready` low.
- R4: While `es_fail`=1, a granted access returns status 2'b11 (DEAD) with data zero. This takes precedence over self-test and over a ready sample.
- R5: While `es_bist`=1 and `es_fail`=0, a granted access returns status 2'b00 (BIST) with data zero and takes no sample.
- R6: A read-only form raises an illegal-instruction exception and takes no sample. `acc_funct3` uses 001/010/011 = register write/set/clear and 101/110/111 = immediate write/set/clear. A read-only form is a set or clear (funct3[1]=1) with `acc_src`=0. Write forms with `acc_src`=0 are not read-only.
- R7: With `ext_enable`=0, every claimed access raises an illegal-instruction exception.
- R8: At privilege level `priv`=2'b11 (machine) with `virt_mode`=0, access is always granted, whatever the enable bits are.
- R9: At `priv`=2'b01 (supervisor), access requires the supervisor enable (configuration bit 9). At `priv`=2'b00 (user), it requires the user enable (bit 8). Without the required bit the access is illegal.
- R10: With `virt_mode`=1, access is never granted. It raises a virtual-instruction exception when bit 9 is set and an illegal-instruction exception otherwise. The two exception outputs are never high together.
- R11: `es_ready` is high only in a cycle where a granted access finds `es_valid`=1, no failure and no self-test. Each such access takes exactly one sample.
- R12: After reset, configuration bits 9 and 8 read back as 0 on `cfg_rdata`. All other `cfg_rdata` bits are 0. `acc_wdata` has no effect on the returned word.
- R13: Any exception response returns an all-zero data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_enable | input | 1 | Entropy extension present/enabled |
| acc_valid | input | 1 | CSR access retiring this cycle |
| acc_csr_num | input | 12 | CSR number of the access |
| acc_funct3 | input | 3 | Instruction form |
| acc_src | input | 5 | Source register index or immediate |
| acc_wdata | input | 32 | Write operand (ignored) |
| priv | input | 2 | Privilege level: 00 user, 01 supervisor, 11 machine |
| virt_mode | input | 1 | Virtualized execution |
| cfg_wr_en | input | 1 | Write strobe for the security configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| es_valid | input | 1 | Entropy sample available |
| es_data | input | 16 | Entropy sample |
| es_fail | input | 1 | Unrecoverable source failure |
| es_bist | input | 1 | Source self-test in progress |
| es_ready | output | 1 | Sample consumed this cycle |
| rsp_valid | output | 1 | Response for a claimed access |
| rsp_rdata | output | 32 | Returned word |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virtual | output | 1 | Virtual-instruction exception |

## Verification
The access check is tried across every privilege level, with and without virtualization, under all four combinations of the two enable bits. This separates the supervisor bit from the user bit and separates the two exception kinds. Instruction forms are swept with a zero and a nonzero source operand, so that read-only set/clear forms are told apart from zero-operand write forms. The source flags are raised in combination (failure together with self-test together with a ready sample) to expose the status priority. Counting `es_ready` pulses shows whether only granted, sample-ready accesses consume.

// File: rtl/seed_pkg.sv
package seed_pkg;

    localparam int WORD_W   = 32;
    localparam int SAMPLE_W = 16;
    localparam int CSRNUM_W = 12;

    typedef enum logic [1:0] {
        ST_BIST = 2'b00,
        ST_WAIT = 2'b01,
        ST_ES16 = 2'b10,
        ST_DEAD = 2'b11
    } opstat_e;

    typedef enum logic [1:0] {
        PL_USER  = 2'b00,
        PL_SUPER = 2'b01,
        PL_MACH  = 2'b11
    } plevel_e;

    typedef enum logic [1:0] {
        VD_GRANT   = 2'b00,
        VD_ILLEGAL = 2'b01,
        VD_VIRTUAL = 2'b10
    } verdict_e;

    typedef struct packed {
        logic sup_en;
        logic usr_en;
    } seed_cfg_t;

    localparam int CFG_USR_BIT = 8;
    localparam int CFG_SUP_BIT = 9;

    // set/clear forms (funct3[1]=1) with a zero operand only read
    function automatic logic is_read_only(input logic [2:0] f3, input logic [4:0] src);
        return f3[1] && (src == 5'd0);
    endfunction

endpackage

// File: rtl/seed_cfg_reg.sv
module seed_cfg_reg
    import seed_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output seed_cfg_t    cfg,
    output logic [W-1:0] rdata
);
    seed_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.sup_en <= wdata[CFG_SUP_BIT];
            cfg_q.usr_en <= wdata[CFG_USR_BIT];
        end
    end

    always_comb begin
        rdata              = '0;
        rdata[CFG_SUP_BIT] = cfg_q.sup_en;
        rdata[CFG_USR_BIT] = cfg_q.usr_en;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/seed_access_check.sv
module seed_access_check
    import seed_pkg::*;
(
    input  logic       ext_enable,
    input  logic [2:0] funct3,
    input  logic [4:0] src,
    input  logic [1:0] priv,
    input  logic       virt_mode,
    input  seed_cfg_t  cfg,
    output verdict_e   verdict
);
    always_comb begin
        verdict = VD_ILLEGAL;
        if (!ext_enable || is_read_only(funct3, src)) begin
            verdict = VD_ILLEGAL;
        end else if (virt_mode) begin
            verdict = cfg.sup_en ? VD_VIRTUAL : VD_ILLEGAL;
        end else begin
            case (plevel_e'(priv))
                PL_MACH:  verdict = VD_GRANT;
                PL_SUPER: verdict = cfg.sup_en ? VD_GRANT : VD_ILLEGAL;
                PL_USER:  verdict = cfg.usr_en ? VD_GRANT : VD_ILLEGAL;
                default:  verdict = VD_ILLEGAL;
            endcase
        end
    end
endmodule

// File: rtl/seed_word_pack.sv
module seed_word_pack
    import seed_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 16
) (
    input  logic          grant,
    input  logic          es_valid,
    input  logic [SW-1:0] es_data,
    input  logic          es_fail,
    input  logic          es_bist,
    output logic          take,
    output logic [W-1:0]  word
);
    localparam int ST_LO = W - 2;

    opstat_e st;

    always_comb begin
        if (es_fail)       st = ST_DEAD;
        else if (es_bist)  st = ST_BIST;
        else if (es_valid) st = ST_ES16;
        else               st = ST_WAIT;
    end

    always_comb begin
        word = '0;
        take = 1'b0;
        if (grant) begin
            word[W-1:ST_LO] = st;
            if (st == ST_ES16) begin
                word[SW-1:0] = es_data;
                take         = 1'b1;
            end
        end
    end
endmodule

// File: rtl/entropy_seed_csr.sv
module entropy_seed_csr
    import seed_pkg::*;
#(
    parameter logic [11:0] SEED_ADDR = 12'h015
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_enable,
    input  logic        acc_valid,
    input  logic [11:0] acc_csr_num,
    input  logic [2:0]  acc_funct3,
    input  logic [4:0]  acc_src,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  priv,
    input  logic        virt_mode,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        es_valid,
    input  logic [15:0] es_data,
    input  logic        es_fail,
    input  logic        es_bist,
    output logic        es_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_illegal,
    output logic        rsp_virtual
);
    seed_cfg_t     cfg;
    verdict_e      verdict;
    logic          claimed;
    logic          grant;
    logic [31:0]   word;
    logic          wdata_unused;

    assign wdata_unused = ^acc_wdata;
    assign claimed      = acc_valid && (acc_csr_num == SEED_ADDR);
    assign grant        = claimed && (verdict == VD_GRANT);

    seed_cfg_reg #(.W(WORD_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    seed_access_check u_chk (
        .ext_enable (ext_enable),
        .funct3     (acc_funct3),
        .src        (acc_src),
        .priv       (priv),
        .virt_mode  (virt_mode),
        .cfg        (cfg),
        .verdict    (verdict)
    );

    seed_word_pack #(.W(WORD_W), .SW(SAMPLE_W)) u_pack (
        .grant    (grant),
        .es_valid (es_valid),
        .es_data  (es_data),
        .es_fail  (es_fail),
        .es_bist  (es_bist),
        .take     (es_ready),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_illegal <= 1'b0;
            rsp_virtual <= 1'b0;
        end else begin
            rsp_valid   <= claimed;
            rsp_rdata   <= word;
            rsp_illegal <= claimed && (verdict == VD_ILLEGAL);
            rsp_virtual <= claimed && (verdict == VD_VIRTUAL);
        end
    end
endmodule

// File: rtl/seed_csr_checker.sv
module seed_csr_checker #(
    parameter logic [11:0] SEED_ADDR = 12'h015
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [11:0] acc_csr_num,
    input logic        es_valid,
    input logic        es_fail,
    input logic        es_bist,
    input logic        es_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_illegal,
    input logic        rsp_virtual
);
    assert_pop_needs_sample_R11: assert property (@(posedge clk) disable iff (rst)
        es_ready |-> (acc_valid && acc_csr_num == SEED_ADDR && es_valid && !es_fail && !es_bist));

    assert_pop_gives_es16_R2: assert property (@(posedge clk) disable iff (rst)
        es_ready |=> (rsp_valid && rsp_rdata[31:30] == 2'b10 && !rsp_illegal && !rsp_virtual));

    assert_resp_only_claimed_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_valid && acc_csr_num == SEED_ADDR));

    assert_exc_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(rsp_illegal && rsp_virtual));

    assert_exc_zero_word_R13: assert property (@(posedge clk) disable iff (rst)
        (rsp_illegal || rsp_virtual) |-> rsp_rdata == 32'd0);

    assert_mid_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_rdata[29:16] == 14'd0);

    assert_no_data_unless_es16_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_rdata[31:30] != 2'b10) |-> rsp_rdata[15:0] == 16'd0);
endmodule

bind entropy_seed_csr seed_csr_checker #(.SEED_ADDR(SEED_ADDR)) u_seed_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_csr_num (acc_csr_num),
    .es_valid    (es_valid),
    .es_fail     (es_fail),
    .es_bist     (es_bist),
    .es_ready    (es_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .rsp_virtual (rsp_virtual)
);

// File: tb/entropy_seed_csr_test.sv
`timescale 1ns/1ps
module entropy_seed_csr_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ext_enable;
    logic        acc_valid;
    logic [11:0] acc_csr_num;
    logic [2:0]  acc_funct3;
    logic [4:0]  acc_src;
    logic [31:0] acc_wdata;
    logic [1:0]  priv;
    logic        virt_mode;
    logic        cfg_wr_en;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        es_valid;
    logic [15:0] es_data;
    logic        es_fail;
    logic        es_bist;
    logic        es_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;
    logic        rsp_virtual;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // sampled results of the last access
    logic        s_ready;
    logic        s_valid;
    logic [31:0] s_word;
    logic        s_ill;
    logic        s_virt;

    always #10 clk = ~clk;

    entropy_seed_csr uut (
        .clk(clk), .rst(rst), .ext_enable(ext_enable),
        .acc_valid(acc_valid), .acc_csr_num(acc_csr_num), .acc_funct3(acc_funct3),
        .acc_src(acc_src), .acc_wdata(acc_wdata), .priv(priv), .virt_mode(virt_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .es_valid(es_valid), .es_data(es_data), .es_fail(es_fail), .es_bist(es_bist),
        .es_ready(es_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal), .rsp_virtual(rsp_virtual)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic sup, input logic usr);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = 32'hFFFF_FCFF | (32'(sup) << 9) | (32'(usr) << 8);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic access(input logic [11:0] num, input logic [2:0] f3, input logic [4:0] src,
                          input logic [1:0] pl, input logic vm, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_csr_num = num; acc_funct3 = f3; acc_src = src;
        priv = pl; virt_mode = vm; acc_wdata = wd;
        #2 s_ready = es_ready;
        @(posedge clk);
        #1;
        s_valid = rsp_valid; s_word = rsp_rdata; s_ill = rsp_illegal; s_virt = rsp_virtual;
        acc_valid = 1'b0;
    endtask

    // expected packed result: {valid, ill, virt, ready, word}
    function automatic logic [63:0] pk(input logic v, input logic i, input logic vi,
                                       input logic r, input logic [31:0] w);
        return {28'd0, v, i, vi, r, w};
    endfunction

    function automatic logic [63:0] got();
        return pk(s_valid, s_ill, s_virt, s_ready, s_word);
    endfunction

    task automatic t_reset();
        check("R12 cfg reset", 64'(cfg_rdata), 64'd0);
        check("R12 rsp reset", pk(rsp_valid, rsp_illegal, rsp_virtual, es_ready, rsp_rdata), 64'd0);
    endtask

    task automatic t_address();
        es_valid = 1; es_data = 16'h1234;
        access(12'h016, 3'b001, 5'd3, 2'b11, 0, 0);
        check("R1 other csr", got(), pk(0, 0, 0, 0, 0));
        access(12'h015, 3'b001, 5'd3, 2'b11, 0, 0);
        check("R1 seed csr", got(), pk(1, 0, 0, 1, 32'h8000_1234));
    endtask

    task automatic t_status();
        es_valid = 1; es_data = 16'hBEEF;
        access(12'h015, 3'b001, 5'd1, 2'b11, 0, 32'hFFFF_FFFF);
        check("R2 es16 wdata ignored R12", got(), pk(1, 0, 0, 1, 32'h8000_BEEF));
        es_data = 16'h0001;
        access(12'h015, 3'b101, 5'd0, 2'b11, 0, 32'h5555_0000);
        check("R2 imm write zero src", got(), pk(1, 0, 0, 1, 32'h8000_0001));
        es_valid = 0;
        access(12'h015, 3'b010, 5'd7, 2'b11, 0, 0);
        check("R3 wait", got(), pk(1, 0, 0, 0, 32'h4000_0000));
        es_valid = 1; es_fail = 1; es_bist = 1;
        access(12'h015, 3'b001, 5'd1, 2'b11, 0, 0);
        check("R4 dead beats bist", got(), pk(1, 0, 0, 0, 32'hC000_0000));
        es_fail = 0;
        access(12'h015, 3'b001, 5'd1, 2'b11, 0, 0);
        check("R5 bist", got(), pk(1, 0, 0, 0, 32'h0000_0000));
        es_bist = 0;
    endtask

    task automatic t_forms();
        es_valid = 1; es_data = 16'hA5A5;
        for (int f = 2; f <= 7; f++) begin
            if (f == 4) continue;
            access(12'h015, 3'(f), 5'd0, 2'b11, 0, 0);
            if (f[1])
                check("R6 read-only form", got(), pk(1, 1, 0, 0, 0));
            else
                check("R6 write form zero src", got(), pk(1, 0, 0, 1, 32'h8000_A5A5));
        end
        access(12'h015, 3'b111, 5'd9, 2'b11, 0, 0);
        check("R6 clear imm nonzero", got(), pk(1, 0, 0, 1, 32'h8000_A5A5));
    endtask

    task automatic t_disabled();
        es_valid = 1; ext_enable = 0;
        access(12'h015, 3'b001, 5'd1, 2'b11, 0, 0);
        check("R7 ext disabled", got(), pk(1, 1, 0, 0, 0));
        ext_enable = 1;
    endtask

    task automatic t_priv();
        es_valid = 1; es_data = 16'h00C3;
        for (int c = 0; c < 4; c++) begin
            logic sup, usr;
            sup = c[1]; usr = c[0];
            set_cfg(sup, usr);
            check("R12 cfg readback", 64'(cfg_rdata), 64'((32'(sup) << 9) | (32'(usr) << 8)));
            access(12'h015, 3'b001, 5'd1, 2'b11, 0, 0);
            check("R8 machine", got(), pk(1, 0, 0, 1, 32'h8000_00C3));
            access(12'h015, 3'b001, 5'd1, 2'b01, 0, 0);
            check("R9 supervisor", got(), sup ? pk(1, 0, 0, 1, 32'h8000_00C3) : pk(1, 1, 0, 0, 0));
            access(12'h015, 3'b001, 5'd1, 2'b00, 0, 0);
            check("R9 user", got(), usr ? pk(1, 0, 0, 1, 32'h8000_00C3) : pk(1, 1, 0, 0, 0));
            access(12'h015, 3'b001, 5'd1, 2'b01, 1, 0);
            check("R10 virt super", got(), sup ? pk(1, 0, 1, 0, 0) : pk(1, 1, 0, 0, 0));
            access(12'h015, 3'b001, 5'd1, 2'b00, 1, 0);
            check("R10 virt user", got(), sup ? pk(1, 0, 1, 0, 0) : pk(1, 1, 0, 0, 0));
        end
        set_cfg(1, 0);
        access(12'h015, 3'b110, 5'd0, 2'b01, 1, 0);
        check("R6 read-only in virt", got(), pk(1, 1, 0, 0, 0));
    endtask

    task automatic t_pop_count();
        int pops = 0;
        es_valid = 1; es_data = 16'h7777;
        for (int k = 0; k < 5; k++) begin
            access(12'h015, 3'b001, 5'd2, 2'b11, 0, 0);
            pops += int'(s_ready);
        end
        access(12'h015, 3'b010, 5'd0, 2'b11, 0, 0);
        pops += int'(s_ready);
        access(12'h020, 3'b001, 5'd2, 2'b11, 0, 0);
        pops += int'(s_ready);
        check("R11 one pop per grant", 64'(pops), 64'd5);
        @(negedge clk);
        check("R11 idle no pop", 64'(es_ready), 64'd0);
    endtask

    initial begin
        rst = 1; ext_enable = 1; acc_valid = 0; acc_csr_num = 0; acc_funct3 = 0;
        acc_src = 0; acc_wdata = 0; priv = 2'b11; virt_mode = 0; cfg_wr_en = 0;
        cfg_wdata = 0; es_valid = 0; es_data = 0; es_fail = 0; es_bist = 0;
        s_ready = 0; s_valid = 0; s_word = 0; s_ill = 0; s_virt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        t_reset();
        t_address();
        t_status();
        t_forms();
        t_disabled();
        t_priv();
        t_pop_count();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule